// File: doc/BRIEF.md
# MDIO Management Interface Master

This block drives the two-wire PHY management bus (MDC clock, bidirectional MDIO data) from one 32-bit command word. Software writes the word with a PHY address, a register address, an operation code and, for a write, sixteen data bits. If the start bit is set and the operation is valid, the block sends one Clause 22 frame. It divides the core clock to make MDC and releases MDIO for the turnaround and data phases of a read. When the frame ends it puts the returned data back into the low half of the same word.

The busy bit in the word stays high for the whole frame and drops when the last bit has been sent. In that same cycle a one-cycle completion pulse is raised, which other logic can turn into an attention event. If the PHY leaves the bus floating high during the turnaround of a read, a read-only failure bit is set. That bit is meaningful once busy has dropped.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset the command word reads 0, MDC is low, MDIO is not driven and the completion pulse is low.
- R2: Command word layout: data [15:0], register address [20:16], PHY address [25:21], operation [27:26] (01 write, 10 read), failure flag [28] (read-only), start/busy [29]. Bits [31:30] read 0. An accepted write stores bits [27:0], except bit 28.
- R3: A frame is 64 bits, each sent MSB first: 32 ones, start code 01, the operation code, PHY address, register address, turnaround, 16 data bits. A write sends turnaround 10 and the data from bits [15:0].
- R4: On a read, MDIO output enable drops for the last 18 bit times (both turnaround bits and all data bits). The 16 data bits sampled from the PHY land in bits [15:0] when the frame ends.
- R5: On a read, if the second turnaround bit is sampled high, bit 28 reads 1 after busy drops. Starting a transaction clears bit 28. A write leaves it 0.
- R6: Bit 29 reads 1 from the cycle after an accepted start until the frame ends, which is exactly 128*(count+1) core cycles.
- R7: A command write while busy is 1 is ignored. The fields and the frame in progress are unchanged.
- R8: MDC is low when idle. While busy its period is 2*(count+1) core cycles, where count is the 5-bit divider input sampled at the start.
- R9: The completion output pulses high for one cycle, once per frame, in the cycle in which busy first reads 0.
- R10: A start with operation 00 or 11 launches no frame. Busy stays 0 and MDC stays low.
- R11: MDIO changes only when MDC falls. Input data is sampled when MDC rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| div_count | input | 5 | MDC divider count, sampled at start |
| cmd_rdata | output | 32 | Current command word, including busy, failure and read data |
| complete | output | 1 | One-cycle pulse when a frame ends |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high drives the bus) |
| mdio_i | input | 1 | MDIO value seen on the bus |

## Verification
The assertions assume that reset is applied before the first command. They assume the divider count only matters at the start and that mdio_i is defined whenever MDC rises. The bench changes all inputs on falling core-clock edges and loads a new divider value only while idle. It acts as the PHY: it changes mdio_i shortly after each MDC rising edge, so the value is stable by the next rise. To model a missing PHY it holds mdio_i high, like a pulled-up bus.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // idle ones sent before every frame
  localparam int PRE_BITS = 32;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_WR   = 2'b01,
    OP_RD   = 2'b10,
    OP_RSV  = 2'b11
  } mdio_op_e;

  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap      = en && (cnt == div);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              last_fall,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_fail
);
  localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
  localparam int DATA_FIRST = TA_FIRST + 2;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_FIRST + 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(TA_FIRST - 1);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_FIRST);

  logic [FRAME_BITS-1:0] frame_w;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [IDX_W-1:0]      idx;
  logic                  rd_q;
  logic                  is_read;
  logic [1:0]            ta_field;
  logic [DATA_W-1:0]     data_field;

  always_comb begin
    is_read    = (op == OP_RD);
    ta_field   = is_read ? 2'b11 : TA_WR;
    data_field = is_read ? '0 : wdata;
    frame_w    = {{PRE_BITS{1'b1}}, ST_CODE, op, phy, regad, ta_field, data_field};
  end

  assign last_fall = fall_tick && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      tx_sh   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_q    <= 1'b0;
      rd_fail <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      idx     <= '0;
      mdio_o  <= frame_w[FRAME_BITS-1];
      tx_sh   <= frame_w << 1;
      mdio_oe <= 1'b1;
      rd_q    <= is_read;
      rd_fail <= 1'b0;
      rd_data <= '0;
    end else begin
      // sample side: MDC rising
      if (rise_tick && rd_q) begin
        if (idx == TA2_IDX && mdio_i)
          rd_fail <= 1'b1;
        if (idx >= DAT_IDX)
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      end
      // launch side: MDC falling
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end else begin
          idx    <= idx + 1'b1;
          mdio_o <= tx_sh[FRAME_BITS-1];
          tx_sh  <= tx_sh << 1;
          if (rd_q && idx >= REL_IDX)
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W  = 5,
  parameter int PHY_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16,
  parameter int WORD_W = DATA_W + REG_W + PHY_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  div_count,
  output logic [WORD_W-1:0] cmd_rdata,
  output logic              complete,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int REG_LSB  = DATA_W;
  localparam int PHY_LSB  = REG_LSB + REG_W;
  localparam int OP_LSB   = PHY_LSB + PHY_W;
  localparam int FAIL_BIT = OP_LSB + 2;
  localparam int BUSY_BIT = FAIL_BIT + 1;

  logic [WORD_W-1:0] cmd_q;
  logic [DIV_W-1:0]  div_q;
  logic              done_q;
  logic              busy;
  logic              wr_ok;
  logic              launch;
  logic [1:0]        wr_op;
  logic              rise_tick;
  logic              fall_tick;
  logic              last_fall;
  logic [DATA_W-1:0] rd_data;
  logic              rd_fail;
  logic              unused_wbits;

  assign busy         = cmd_q[BUSY_BIT];
  assign wr_op        = cmd_wdata[OP_LSB +: 2];
  assign wr_ok        = cmd_wr && !busy;
  assign launch       = wr_ok && cmd_wdata[BUSY_BIT] && (wr_op == OP_WR || wr_op == OP_RD);
  assign unused_wbits = ^{cmd_wdata[WORD_W-1:BUSY_BIT+1], cmd_wdata[FAIL_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_fall;
      if (wr_ok) begin
        cmd_q[OP_LSB+1:0] <= cmd_wdata[OP_LSB+1:0];
        cmd_q[BUSY_BIT]   <= launch;
        if (launch) begin
          cmd_q[FAIL_BIT] <= 1'b0;
          div_q           <= div_count;
        end
      end else if (last_fall) begin
        cmd_q[BUSY_BIT] <= 1'b0;
        if (cmd_q[OP_LSB +: 2] == OP_RD) begin
          cmd_q[DATA_W-1:0] <= rd_data;
          cmd_q[FAIL_BIT]   <= rd_fail;
        end
      end
    end
  end

  assign cmd_rdata = cmd_q;
  assign complete  = done_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst       (rst),
    .en        (busy),
    .div       (div_q),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (launch),
    .op        (wr_op),
    .phy       (cmd_wdata[PHY_LSB +: PHY_W]),
    .regad     (cmd_wdata[REG_LSB +: REG_W]),
    .wdata     (cmd_wdata[DATA_W-1:0]),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .last_fall (last_fall),
    .rd_data   (rd_data),
    .rd_fail   (rd_fail)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int WORD_W   = 32,
  parameter int REG_LSB  = 16,
  parameter int OP_LSB   = 26,
  parameter int FAIL_BIT = 28,
  parameter int BUSY_BIT = 29
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] cmd_rdata,
  input logic              complete,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  logic busy;
  assign busy = cmd_rdata[BUSY_BIT];

  // R8: clock parked low whenever idle
  a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R4: bus released once no frame is running
  a_r4_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  // R9: completion only at the end of a frame
  a_r9_complete_at_end: assert property (@(posedge clk) disable iff (rst)
    complete |-> (!busy && $past(busy)));

  // R7: address and operation fields frozen during a frame
  a_r7_fields_held: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_rdata[OP_LSB+1:REG_LSB]));

  // R11: data line moves only on a falling MDC
  a_r11_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && (mdc || !$past(mdc))) |-> $stable(mdio_o));

  // R5: failure flag only changes at frame start or end
  a_r5_fail_at_bounds: assert property (@(posedge clk) disable iff (rst)
    (!$rose(busy) && !$fell(busy)) |-> $stable(cmd_rdata[FAIL_BIT]));

  // R10: frames start only with a valid operation
  a_r10_valid_launch: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (cmd_rdata[OP_LSB +: 2] == 2'b01 || cmd_rdata[OP_LSB +: 2] == 2'b10));
endmodule

bind mdio_master mdio_master_chk #(
  .WORD_W(32), .REG_LSB(16), .OP_LSB(26), .FAIL_BIT(28), .BUSY_BIT(29)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_rdata (cmd_rdata),
  .complete  (complete),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [4:0]  div_count = '0;
  logic [31:0] cmd_rdata;
  logic        complete, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  mdio_master uut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .div_count(div_count), .cmd_rdata(cmd_rdata), .complete(complete),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // PHY model: records bits at MDC rise, answers reads
  int          phy_k = 0;
  bit          phy_resp = 1'b1;
  logic [15:0] phy_val = '0;
  logic [63:0] cap_fr = '0;
  logic [63:0] cap_oe = '0;
  int          last_rise = 0;
  int          mdc_per = 0;

  always @(posedge mdc) begin
    mdc_per   = cyc - last_rise;
    last_rise = cyc;
    if (phy_k < 64) begin
      cap_fr[63-phy_k] = mdio_o;
      cap_oe[63-phy_k] = mdio_oe;
    end
    phy_k++;
    #1;
    if (phy_resp && phy_k >= 47 && phy_k <= 63 && cap_fr[29:28] == 2'b10)
      mdio_i = (phy_k == 47) ? 1'b0 : phy_val[63-phy_k];
    else
      mdio_i = 1'b1;
  end

  // scoreboard
  typedef struct packed {
    logic [31:0] word;
    logic [63:0] frame;
    logic [63:0] oe;
  } exp_t;
  exp_t sbq[$];
  exp_t e;

  initial begin
    forever begin
      @(negedge clk);
      if (complete) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R9 completion with nothing pending", 64'd1, 64'd0);
        end else begin
          e = sbq.pop_front();
          chk(cmd_rdata == e.word, "R2 R4 R5 word after frame", cmd_rdata, e.word);
          chk((cap_fr & e.oe) == (e.frame & e.oe), "R3 R11 frame bits at MDC rise", cap_fr, e.frame);
          chk(cap_oe == e.oe, "R4 drive enable per bit", cap_oe, e.oe);
        end
      end
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] data, input logic [4:0] div,
                         input bit resp, input logic [15:0] rval, input bit poke);
    logic [31:0] word;
    exp_t x;
    int cnt;
    bit rd;
    rd   = (op == 2'b10);
    word = {2'b00, 1'b1, 1'b0, op, phy, rg, data};
    x.frame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, rd ? 2'b11 : 2'b10, rd ? rval : data};
    x.oe    = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    x.word  = rd ? {2'b00, 1'b0, !resp, op, phy, rg, resp ? rval : 16'hFFFF}
                 : {4'b0000, op, phy, rg, data};
    sbq.push_back(x);
    phy_k = 0; phy_resp = resp; phy_val = rval; div_count = div;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = word;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[29] == 1'b1, "R6 busy after start", cmd_rdata[29], 1);
    cnt = 0;
    while (cmd_rdata[29] === 1'b1) begin
      cnt++;
      if (poke && cnt == 10) begin
        cmd_wr = 1'b1; cmd_wdata = 32'h27FF_1234;
      end
      if (poke && cnt == 11) begin
        cmd_wr = 1'b0;
        chk(cmd_rdata[27:0] == {word[27:26], word[25:0]} && cmd_rdata[29],
            "R7 write while busy ignored", cmd_rdata, word);
      end
      @(negedge clk);
    end
    chk(cnt == 128 * (int'(div) + 1), "R6 frame length", cnt, 128 * (int'(div) + 1));
    chk(mdc_per == 2 * (int'(div) + 1), "R8 MDC period", mdc_per, 2 * (int'(div) + 1));
    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R9 one completion per frame", sbq.size(), 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle MDC low, bus released", {mdc, mdio_oe}, 0);
  endtask

  task automatic bad_op(input logic [1:0] op);
    logic [31:0] word;
    word = {2'b00, 1'b1, 1'b0, op, 5'h0A, 5'h15, 16'h5A5A};
    phy_k = 0;
    @(negedge clk);
    cmd_wr = 1'b1; cmd_wdata = word;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_rdata[29] == 1'b0, "R10 invalid op leaves busy low", cmd_rdata[29], 0);
    chk(cmd_rdata[27:0] == word[27:0], "R2 fields stored on idle write", cmd_rdata[27:0], word[27:0]);
    repeat (20) @(negedge clk);
    chk(phy_k == 0 && mdc == 1'b0 && complete == 1'b0, "R10 no frame for invalid op", phy_k, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata == 32'h0, "R1 word after reset", cmd_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && complete == 1'b0, "R1 outputs after reset",
        {mdc, mdio_oe, complete}, 0);

    run_txn(2'b01, 5'h01, 5'h1F, 16'hA5C3, 5'd0, 1'b1, 16'h0000, 1'b0);
    run_txn(2'b01, 5'h1E, 5'h00, 16'h0001, 5'd3, 1'b1, 16'h0000, 1'b0);
    run_txn(2'b10, 5'h03, 5'h02, 16'h0000, 5'd1, 1'b1, 16'h1234, 1'b0);
    run_txn(2'b10, 5'h11, 5'h0C, 16'h0000, 5'd0, 1'b0, 16'h0000, 1'b0);
    run_txn(2'b10, 5'h07, 5'h19, 16'h0000, 5'd2, 1'b1, 16'hFEDC, 1'b0);
    run_txn(2'b01, 5'h15, 5'h0A, 16'h3C96, 5'd1, 1'b1, 16'h0000, 1'b1);
    bad_op(2'b11);
    bad_op(2'b00);
    run_txn(2'b10, 5'h00, 5'h01, 16'h0000, 5'd0, 1'b1, 16'h8001, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule